// File: doc/BRIEF.md
# Dual Synthesizer Serial Loader

This block programs two external frequency synthesizers, one serving each pair of converters, from a single configuration image. Both synthesizers sit on the same serial clock and data wires, so one transfer writes both at once. Software first writes the configuration image to address 0x0. It then writes any value to address 0xF to start the transfer. The block takes a copy of the image, shifts it out bit by bit and ends with a load strobe. The synthesizers cannot be read back, so the block has no readback path.

A command at address 0xD stops the synthesizer outputs through a halt line. It does not clear the stored settings. The next completed load releases the halt. Two clock-select bits of the image are passed straight through as static outputs.

Top module: `synth_loader`

## Requirements
- R1: After reset, ser_clk, ser_data, ser_load, busy, done and synth_halt are 0 and clk_sel is 0.
- R2: Only a write to address 0xF starts a transfer. Writes to any other address, such as 0x0 or 0x3, leave busy at 0 and leave ser_clk still.
- R3: The configuration image holds these fields:
  - bits [8:0]: M of pair A/B
  - bits [11:9]: N of pair A/B
  - bits [20:12]: M of pair C/D
  - bits [23:21]: N of pair C/D
  - bit 24: clock select A/B
  - bit 25: clock select C/D

  A transfer sends image bits 23 down to 0, most significant first, on exactly 24 rising edges of ser_clk. ser_data changes only while ser_clk is low.
- R4: ser_clk has a period of DIV system cycles (default 8) and is high for DIV/2 of them.
- R5: After the last bit, ser_load is high for exactly DIV cycles. ser_clk stays low during that time.
- R6: busy is high for 24*DIV+DIV cycles (200 at default) from the cycle after the start. It is followed by a single-cycle done pulse, during which busy is low.
- R7: The image is copied at the start. A write to 0x0 during a transfer does not change the bits in flight, but it is used by the next transfer.
- R8: A start request made while busy is held. The held transfer begins in the cycle right after done and uses the image as it is at that point. Several requests made while busy merge into one transfer.
- R9: A write to 0xD raises synth_halt from the next cycle. synth_halt stays high until a load completes and falls in the cycle after that load's done. The image and clk_sel are kept, so the next load shifts the same bits.
- R10: clk_sel[0] equals image bit 24 and clk_sel[1] equals image bit 25. Both follow writes to 0x0 from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Control write strobe |
| wr_addr | input | 4 | Control write address |
| wr_data | input | 26 | Control write data |
| ser_clk | output | 1 | Shared serial clock to both synthesizers |
| ser_data | output | 1 | Shared serial data |
| ser_load | output | 1 | Load strobe after the last bit |
| synth_halt | output | 1 | Stops synthesizer outputs, settings kept |
| clk_sel | output | 2 | Static clock-select bits, one per pair |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
If the bit counter or the shift copy goes wrong, the 24-bit word captured on the ser_clk rising edges will differ from the image written. This shows up by the end of the first transfer. If the phase counter goes wrong, the ser_clk high time, the period or the ser_load width is off, and this is visible within one serial period. A wrong start or held-request flag shows up as a busy window of the wrong length, a missing or extra transfer after done, or a halt line that never clears. Each of these is visible within about one transfer length, roughly 210 cycles.

// File: rtl/synth_ld_pkg.sv
package synth_ld_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_LOAD  = 2'd2,
    ST_FIN   = 2'd3
  } ser_state_e;

  localparam logic [3:0] ADDR_CFG_DEF  = 4'h0;
  localparam logic [3:0] ADDR_GRES_DEF = 4'hD;
  localparam logic [3:0] ADDR_LOAD_DEF = 4'hF;
endpackage

// File: rtl/synth_cfg_regs.sv
module synth_cfg_regs #(
  parameter int M_W = 9,
  parameter int N_W = 3,
  parameter logic [3:0] ADDR_CFG  = synth_ld_pkg::ADDR_CFG_DEF,
  parameter logic [3:0] ADDR_GRES = synth_ld_pkg::ADDR_GRES_DEF,
  parameter logic [3:0] ADDR_LOAD = synth_ld_pkg::ADDR_LOAD_DEF,
  localparam int PAIR_W  = M_W + N_W,
  localparam int FRAME_W = 2 * PAIR_W,
  localparam int REG_W   = FRAME_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [3:0]         wr_addr,
  input  logic [REG_W-1:0]   wr_data,
  input  logic               done_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic [1:0]         clk_sel_o,
  output logic               load_req_o,
  output logic               halt_o
);
  logic [REG_W-1:0] image_q;
  logic             gres_req;
  logic [M_W-1:0]   m_fld [2];
  logic [N_W-1:0]   n_fld [2];

  function automatic logic hit(input logic en, input logic [3:0] a, input logic [3:0] ref_a);
    return en && (a == ref_a);
  endfunction

  assign load_req_o = hit(wr_en, wr_addr, ADDR_LOAD);
  assign gres_req   = hit(wr_en, wr_addr, ADDR_GRES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      image_q <= '0;
    end else if (hit(wr_en, wr_addr, ADDR_CFG)) begin
      image_q <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_o <= 1'b0;
    end else if (gres_req) begin
      halt_o <= 1'b1;
    end else if (done_i) begin
      halt_o <= 1'b0;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_pair
    assign m_fld[g] = image_q[g*PAIR_W +: M_W];
    assign n_fld[g] = image_q[g*PAIR_W + M_W +: N_W];
    assign frame_o[g*PAIR_W +: PAIR_W] = {n_fld[g], m_fld[g]};
    assign clk_sel_o[g] = image_q[FRAME_W + g];
  end
endmodule

// File: rtl/synth_ser_engine.sv
module synth_ser_engine
  import synth_ld_pkg::*;
#(
  parameter int FRAME_W = 24,
  parameter int DIV     = 8,
  localparam int PH_W   = (DIV > 2) ? $clog2(DIV) : 1,
  localparam int IDX_W  = $clog2(FRAME_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_req,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               ser_clk,
  output logic               ser_data,
  output logic               ser_load,
  output logic               busy,
  output logic               done
);
  ser_state_e         state_q;
  logic [PH_W-1:0]    phase_q;
  logic [IDX_W-1:0]   idx_q;
  logic [FRAME_W-1:0] shreg_q;
  logic               pend_q;
  logic               can_start;
  logic               accept;
  logic               period_end;

  function automatic logic [PH_W-1:0] phase_next(input logic [PH_W-1:0] p);
    return (p == PH_W'(DIV - 1)) ? '0 : p + 1'b1;
  endfunction

  assign can_start  = (state_q == ST_IDLE) || (state_q == ST_FIN);
  assign accept     = can_start && (load_req || pend_q);
  assign period_end = (phase_q == PH_W'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (accept) begin
      pend_q <= 1'b0;
    end else if (load_req) begin
      pend_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= '0;
      idx_q   <= '0;
      shreg_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE, ST_FIN: begin
          if (accept) begin
            state_q <= ST_SHIFT;
            phase_q <= '0;
            idx_q   <= IDX_W'(FRAME_W - 1);
            shreg_q <= frame_i;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        ST_SHIFT: begin
          phase_q <= phase_next(phase_q);
          if (period_end) begin
            if (idx_q == '0) begin
              state_q <= ST_LOAD;
            end else begin
              idx_q   <= idx_q - 1'b1;
              shreg_q <= {shreg_q[FRAME_W-2:0], 1'b0};
            end
          end
        end
        ST_LOAD: begin
          phase_q <= phase_next(phase_q);
          if (period_end) state_q <= ST_FIN;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ser_clk  = (state_q == ST_SHIFT) && (phase_q >= PH_W'(DIV / 2));
  assign ser_data = (state_q == ST_SHIFT) && shreg_q[FRAME_W-1];
  assign ser_load = (state_q == ST_LOAD);
  assign busy     = (state_q == ST_SHIFT) || (state_q == ST_LOAD);
  assign done     = (state_q == ST_FIN);
endmodule

// File: rtl/synth_loader.sv
module synth_loader #(
  parameter int M_W = 9,
  parameter int N_W = 3,
  parameter int DIV = 8,
  localparam int FRAME_W = 2 * (M_W + N_W),
  localparam int REG_W   = FRAME_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [3:0]       wr_addr,
  input  logic [REG_W-1:0] wr_data,
  output logic             ser_clk,
  output logic             ser_data,
  output logic             ser_load,
  output logic             synth_halt,
  output logic [1:0]       clk_sel,
  output logic             busy,
  output logic             done
);
  wire               load_req;
  wire [FRAME_W-1:0] frame;

  synth_cfg_regs #(.M_W(M_W), .N_W(N_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .done_i    (done),
    .frame_o   (frame),
    .clk_sel_o (clk_sel),
    .load_req_o(load_req),
    .halt_o    (synth_halt)
  );

  synth_ser_engine #(.FRAME_W(FRAME_W), .DIV(DIV)) u_eng (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_req(load_req),
    .frame_i (frame),
    .ser_clk (ser_clk),
    .ser_data(ser_data),
    .ser_load(ser_load),
    .busy    (busy),
    .done    (done)
  );
endmodule

// File: rtl/synth_loader_chk.sv
module synth_loader_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [3:0] wr_addr,
  input logic       ser_clk,
  input logic       ser_data,
  input logic       ser_load,
  input logic       synth_halt,
  input logic       busy,
  input logic       done,
  input logic       load_req
);
  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && load_req) |=> busy);

  p_data_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk && $past(ser_clk)) |-> $stable(ser_data));

  p_load_clk_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ser_load |-> (!ser_clk && busy));

  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_load_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_load) |-> done);

  p_halt_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 4'hD) |=> synth_halt);

  p_halt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (synth_halt && !done) |=> synth_halt);
endmodule

bind synth_loader synth_loader_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .ser_clk   (ser_clk),
  .ser_data  (ser_data),
  .ser_load  (ser_load),
  .synth_halt(synth_halt),
  .busy      (busy),
  .done      (done),
  .load_req  (load_req)
);

// File: tb/test_synth_loader.sv
`timescale 1ns/1ps
module test_synth_loader;
  localparam int DIV = 8;
  localparam int FW  = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [25:0] wr_data = '0;
  logic        ser_clk, ser_data, ser_load, synth_halt, busy, done;
  logic [1:0]  clk_sel;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  synth_loader i_synth_loader (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ser_clk(ser_clk), .ser_data(ser_data), .ser_load(ser_load),
    .synth_halt(synth_halt), .clk_sel(clk_sel), .busy(busy), .done(done)
  );

  // monitor, samples on the falling system clock edge
  int cyc = 0;
  logic prev_clk = 1'b0;
  logic [FW-1:0] cur_frame = '0;
  int cur_rises = 0, cur_busy = 0, cur_load = 0, cur_clk_in_load = 0;
  int hi_run = 0, last_hi = 0, last_rise = -1, last_period = 0;
  int nx = 0;
  int idle_rises = 0;
  logic [FW-1:0] rec_frame [8];
  int rec_rises [8], rec_busy [8], rec_load [8], rec_cil [8], rec_hi [8], rec_per [8];

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) cur_busy++;
      if (ser_load) begin
        cur_load++;
        if (ser_clk) cur_clk_in_load++;
      end
      if (ser_clk && !prev_clk) begin
        cur_frame = {cur_frame[FW-2:0], ser_data};
        cur_rises++;
        if (!busy) idle_rises++;
        if (last_rise >= 0) last_period = cyc - last_rise;
        last_rise = cyc;
      end
      if (ser_clk) hi_run++;
      else if (prev_clk) begin last_hi = hi_run; hi_run = 0; end
      if (done && nx < 8) begin
        rec_frame[nx] = cur_frame; rec_rises[nx] = cur_rises; rec_busy[nx] = cur_busy;
        rec_load[nx] = cur_load; rec_cil[nx] = cur_clk_in_load;
        rec_hi[nx] = last_hi; rec_per[nx] = last_period;
        nx++;
        cur_frame = '0; cur_rises = 0; cur_busy = 0; cur_load = 0;
        cur_clk_in_load = 0; last_rise = -1;
      end
      prev_clk = ser_clk;
    end
    cyc++;
  end

  function automatic logic [25:0] mk_img(input logic [8:0] m_ab, input logic [2:0] n_ab,
                                         input logic [8:0] m_cd, input logic [2:0] n_cd,
                                         input logic s_ab, input logic s_cd);
    logic [25:0] v;
    v = '0;
    v[8:0] = m_ab; v[11:9] = n_ab; v[20:12] = m_cd; v[23:21] = n_cd;
    v[24] = s_ab; v[25] = s_cd;
    return v;
  endfunction

  function automatic logic [FW-1:0] exp_frame(input logic [25:0] img);
    logic [FW-1:0] f;
    for (int i = 0; i < FW; i++) f[i] = img[i];
    return f;
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); #1; end
  endtask

  task automatic wr(input logic [3:0] a, input logic [25:0] d);
    @(negedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); #1;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic wait_xfers(input int n);
    int t;
    t = 0;
    while (nx < n && t < 2000) begin @(negedge clk); #1; t++; end
  endtask

  task automatic check_xfer(input int k, input logic [25:0] img, input string tag);
    chk(rec_frame[k] == exp_frame(img), {tag, " frame bits"}, int'(rec_frame[k]), int'(exp_frame(img)));
    chk(rec_rises[k] == FW, {tag, " rising edges"}, rec_rises[k], FW);
  endtask

  task automatic t_reset;
    chk(!ser_clk && !ser_data && !ser_load, "R1 serial lines", {ser_clk, ser_data, ser_load}, 0);
    chk(!busy && !done, "R1 busy/done", {busy, done}, 0);
    chk(!synth_halt && clk_sel == 2'b00, "R1 halt/clk_sel", {synth_halt, clk_sel}, 0);
  endtask

  task automatic t_no_trigger;
    logic [25:0] img;
    int seen;
    img = mk_img(9'h1A5, 3'd5, 9'h0F3, 3'd2, 1'b1, 1'b0);
    wr(4'h0, img);
    wr(4'h3, 26'h3FFFFFF);
    seen = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); #1; if (busy || ser_clk) seen++; end
    chk(seen == 0 && nx == 0, "R2 no start on other addresses", seen, 0);
    chk(clk_sel == 2'b01, "R10 clk_sel follows image", clk_sel, 1);
  endtask

  task automatic t_single;
    logic [25:0] img;
    img = mk_img(9'h1A5, 3'd5, 9'h0F3, 3'd2, 1'b1, 1'b0);
    wr(4'hF, 26'h0);
    wait_xfers(1);
    check_xfer(0, img, "R3 single");
    chk(rec_hi[0] == DIV / 2, "R4 high time", rec_hi[0], DIV / 2);
    chk(rec_per[0] == DIV, "R4 period", rec_per[0], DIV);
    chk(rec_load[0] == DIV, "R5 load width", rec_load[0], DIV);
    chk(rec_cil[0] == 0, "R5 clock low during load", rec_cil[0], 0);
    chk(rec_busy[0] == FW * DIV + DIV, "R6 busy length", rec_busy[0], FW * DIV + DIV);
    tick(1);
    chk(!done && !busy, "R6 done one cycle then idle", {done, busy}, 0);
    tick(20);
    chk(nx == 1 && idle_rises == 0, "R6 no extra transfer", nx, 1);
  endtask

  task automatic t_snapshot;
    logic [25:0] a, b;
    a = mk_img(9'h155, 3'd3, 9'h0AA, 3'd6, 1'b0, 1'b1);
    b = mk_img(9'h0C3, 3'd1, 9'h13C, 3'd7, 1'b1, 1'b1);
    wr(4'h0, a);
    wr(4'hF, 26'h0);
    tick(30);
    wr(4'h0, b);
    chk(clk_sel == 2'b11, "R10 clk_sel update mid transfer", clk_sel, 3);
    wait_xfers(2);
    check_xfer(1, a, "R7 snapshot in flight");
    tick(3);
    wr(4'hF, 26'h0);
    wait_xfers(3);
    check_xfer(2, b, "R7 new image next transfer");
  endtask

  task automatic t_pending;
    logic [25:0] a, b;
    int base;
    a = mk_img(9'h001, 3'd0, 9'h100, 3'd4, 1'b0, 1'b0);
    b = mk_img(9'h1FF, 3'd7, 9'h000, 3'd0, 1'b0, 1'b0);
    base = nx;
    wr(4'h0, a);
    wr(4'hF, 26'h0);
    tick(50);
    wr(4'h0, b);
    wr(4'hF, 26'h0);
    tick(10);
    wr(4'hF, 26'h0);
    wait_xfers(base + 1);
    check_xfer(base, a, "R8 first transfer");
    tick(1);
    chk(busy == 1'b1, "R8 held request starts right after done", busy, 1);
    wait_xfers(base + 2);
    check_xfer(base + 1, b, "R8 held transfer uses current image");
    chk(rec_busy[base + 1] == FW * DIV + DIV, "R8 held transfer busy length", rec_busy[base + 1], FW * DIV + DIV);
    tick(40);
    chk(nx == base + 2, "R8 requests merged", nx, base + 2);
  endtask

  task automatic t_gres;
    logic [25:0] b;
    int base;
    b = mk_img(9'h1FF, 3'd7, 9'h000, 3'd0, 1'b0, 1'b0);
    base = nx;
    wr(4'hD, 26'h0);
    chk(synth_halt == 1'b1, "R9 halt raised", synth_halt, 1);
    tick(25);
    chk(synth_halt == 1'b1 && !busy, "R9 halt held, no transfer", {synth_halt, busy}, 2);
    chk(clk_sel == 2'b00, "R9 clk_sel kept", clk_sel, 0);
    wr(4'hF, 26'h0);
    tick(60);
    chk(synth_halt == 1'b1, "R9 halt during load", synth_halt, 1);
    wait_xfers(base + 1);
    check_xfer(base, b, "R9 image kept after halt");
    tick(1);
    chk(synth_halt == 1'b0, "R9 halt released after load", synth_halt, 0);
  endtask

  initial begin
    tick(3);
    t_reset;
    rst_n = 1'b1;
    tick(2);
    t_reset;
    t_no_trigger;
    t_single;
    t_snapshot;
    t_pending;
    t_gres;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule